// File: doc/BRIEF.md
# Linked-Descriptor DMA Fetch Unit

This block is the descriptor-fetch front end of a multi-channel scatter-gather DMA. Each channel holds a control word plus count, source, destination and next-pointer registers. When the data-moving engine reports that a channel's current transfer has finished, the block decides whether the chain goes on.

If the chain goes on, the block reads a four-word descriptor through a shared 32-bit read port, loads it into the channel's registers and signals the engine to start again. If the chain has ended, because the channel is in unchained mode or because its next pointer is zero, the block closes the chain. It may set a per-channel completion bit in a shared interrupt status register, and it always clears the channel's active control bits.

Software or a surrounding controller programs each channel's control word and first next pointer through a simple load port. The interrupt line is the OR of the status bits that are enabled by a mask. Status bits are cleared by writing ones to the clear input.

Top module: `dma_desc_fetch`

## Requirements
- R1: A descriptor fetch issues exactly four reads, at addresses P, P+4, P+8 and P+12, where P is the channel's next pointer when the fetch begins.
- R2: The four returned words load, in read order, the channel's byte count, source address, destination address and next pointer.
- R3: The block never has more than one read in flight. A new `rd_req` is raised only after the `rd_valid` for the previous read has been seen.
- R4: When control bit 9 (unchained mode) is set and `xfer_done` arrives, the chain ends. No read is issued, and the count, source, destination and next registers keep their values.
- R5: When the next pointer is zero and `xfer_done` arrives, the chain ends and no read is issued.
- R6: At the end of a chain, if control bit 10 is set, status bit (CMP_SHIFT + channel) becomes 1 in the cycle after `xfer_done`. If bit 10 is clear, the status register is left unchanged.
- R7: At the end of a chain, control bits 12 and 14 of that channel become 0 and every other control bit is kept.
- R8: The result is reported per channel. `xfer_start[i]` is a one-cycle pulse in the cycle after the last descriptor word returns, meaning a descriptor was loaded. `chain_end[i]` is a one-cycle pulse in the cycle after `xfer_done[i]`, meaning the chain ended. The two never pulse together for the same channel.
- R9: `irq` equals the OR of (`irq_status` AND `irq_mask`) in the same cycle. A status bit stays at 1 until a 1 is written to the matching `irq_clr` bit. A set in the same cycle as a clear wins.
- R10: When several channels end their chains in the same cycle, every one of their enabled completion bits is set.
- R11: When several channels request a fetch together, they are served one at a time, lowest channel index first. Each fetch completes all four reads before the next one starts.
- R12: After reset, all channel registers, `irq_status`, `irq`, `rd_req`, `xfer_start` and `chain_end` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the control word and next pointer of channel `ld_ch` |
| ld_ch | input | CHW | Channel selected for loading |
| ld_ctrl | input | CW | Control word to load |
| ld_next | input | AW | First descriptor pointer to load |
| xfer_done | input | NCH | Per-channel pulse: the current transfer has finished |
| xfer_start | output | NCH | Per-channel pulse: a new descriptor is loaded, continue |
| chain_end | output | NCH | Per-channel pulse: the chain has finished |
| rd_req | output | 1 | Read request, one cycle per word |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DW | Read data |
| ctrl_q | output | NCH*CW | Control words, channel 0 in the low bits |
| count_q | output | NCH*DW | Byte counts |
| src_q | output | NCH*AW | Source addresses |
| dst_q | output | NCH*AW | Destination addresses |
| next_q | output | NCH*AW | Next-descriptor pointers |
| irq_status | output | SW | Shared interrupt status |
| irq_clr | input | SW | Write-1-to-clear for status bits |
| irq_mask | input | SW | Interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
A two-link chain on one channel checks the fetch-and-load path and then the zero-pointer end in turn. The descriptor words are all distinct, so a swapped field or a wrong address step shows up.

Unchained mode is tried with a non-zero pointer, which separates the mode-bit exit from the zero-pointer exit. The interrupt-enable bit is tried both set and clear, to show that only the status update depends on it while the clearing of the active bits does not.

Two channels are then made to end in the same cycle, and in another test to request fetches in the same cycle. These show that no status bit is lost and that reads from the two fetches never interleave. Read latency is varied between tests to show the design does not rely on a fixed return delay.

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int SW        = 8,
  parameter int CMP_SHIFT = 4,
  parameter int UNCH_BIT  = 9,
  parameter int IRQEN_BIT = 10,
  parameter int ACT_LO    = 12,
  parameter int ACT_HI    = 14,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CHW-1:0]    ld_ch,
  input  logic [CW-1:0]     ld_ctrl,
  input  logic [AW-1:0]     ld_next,
  input  logic [NCH-1:0]    xfer_done,
  output logic [NCH-1:0]    xfer_start,
  output logic [NCH-1:0]    chain_end,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [DW-1:0]     rd_data,
  output logic [NCH*CW-1:0] ctrl_q,
  output logic [NCH*DW-1:0] count_q,
  output logic [NCH*AW-1:0] src_q,
  output logic [NCH*AW-1:0] dst_q,
  output logic [NCH*AW-1:0] next_q,
  output logic [SW-1:0]     irq_status,
  input  logic [SW-1:0]     irq_clr,
  input  logic [SW-1:0]     irq_mask,
  output logic              irq
);

  localparam logic [CW-1:0] ACT_MASK = CW'((1 << ACT_LO) | (1 << ACT_HI));

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  logic [CW-1:0]  ctrl_r [NCH];
  logic [DW-1:0]  cnt_r  [NCH];
  logic [AW-1:0]  src_r  [NCH];
  logic [AW-1:0]  dst_r  [NCH];
  logic [AW-1:0]  nxt_r  [NCH];
  logic [NCH-1:0] pend;
  logic [NCH-1:0] busy, end_now, go_now;
  logic [SW-1:0]  set_vec;
  state_t         state;
  logic [CHW-1:0] cur, pick;
  logic [1:0]     idx;
  logic [AW-1:0]  base;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign busy[g]    = pend[g] || (state != S_IDLE && cur == CHW'(g));
      assign end_now[g] = xfer_done[g] && !busy[g] &&
                          (ctrl_r[g][UNCH_BIT] || nxt_r[g] == '0);
      assign go_now[g]  = xfer_done[g] && !busy[g] && !end_now[g];
      assign ctrl_q [g*CW +: CW] = ctrl_r[g];
      assign count_q[g*DW +: DW] = cnt_r[g];
      assign src_q  [g*AW +: AW] = src_r[g];
      assign dst_q  [g*AW +: AW] = dst_r[g];
      assign next_q [g*AW +: AW] = nxt_r[g];
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NCH; i++)
      if (end_now[i] && ctrl_r[i][IRQEN_BIT]) set_vec[CMP_SHIFT + i] = 1'b1;
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CHW'(i);
  end

  assign rd_req  = (state == S_ISSUE);
  assign rd_addr = base + {{(AW-4){1'b0}}, idx, 2'b00};
  assign irq     = |(irq_status & irq_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl_r[i] <= '0;
        cnt_r[i]  <= '0;
        src_r[i]  <= '0;
        dst_r[i]  <= '0;
        nxt_r[i]  <= '0;
      end
      pend       <= '0;
      state      <= S_IDLE;
      cur        <= '0;
      idx        <= '0;
      base       <= '0;
      xfer_start <= '0;
      chain_end  <= '0;
      irq_status <= '0;
    end else begin
      xfer_start <= '0;
      chain_end  <= end_now;
      irq_status <= (irq_status & ~irq_clr) | set_vec;
      for (int i = 0; i < NCH; i++) begin
        if (end_now[i]) ctrl_r[i] <= ctrl_r[i] & ~ACT_MASK;
        if (go_now[i])  pend[i]   <= 1'b1;
      end
      if (ld_en) begin
        ctrl_r[ld_ch] <= ld_ctrl;
        nxt_r[ld_ch]  <= ld_next;
      end
      case (state)
        S_IDLE: if (|pend) begin
          cur   <= pick;
          base  <= nxt_r[pick];
          idx   <= '0;
          state <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          case (idx)
            2'd0:    cnt_r[cur] <= rd_data;
            2'd1:    src_r[cur] <= AW'(rd_data);
            2'd2:    dst_r[cur] <= AW'(rd_data);
            default: nxt_r[cur] <= AW'(rd_data);
          endcase
          if (idx == 2'd3) begin
            state           <= S_IDLE;
            pend[cur]       <= 1'b0;
            xfer_start[cur] <= 1'b1;
          end else begin
            idx   <= idx + 2'd1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_desc_fetch_chk.sv
module dma_desc_fetch_chk #(
  parameter int NCH       = 2,
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int SW        = 8,
  parameter int CMP_SHIFT = 4,
  parameter int IRQEN_BIT = 10,
  parameter int ACT_LO    = 12,
  parameter int ACT_HI    = 14,
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [CHW-1:0]    ld_ch,
  input logic              rd_req,
  input logic [AW-1:0]     rd_addr,
  input logic              rd_valid,
  input logic [NCH-1:0]    xfer_start,
  input logic [NCH-1:0]    chain_end,
  input logic [NCH*CW-1:0] ctrl_q,
  input logic [SW-1:0]     irq_status,
  input logic [SW-1:0]     irq_clr
);

  logic          outst;
  logic [1:0]    nreq;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst     <= 1'b0;
      nreq      <= '0;
      last_addr <= '0;
    end else begin
      if (rd_valid) outst <= 1'b0;
      if (rd_req) begin
        outst     <= 1'b1;
        nreq      <= nreq + 2'd1;
        last_addr <= rd_addr;
      end
    end
  end

  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outst);

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && nreq != 2'd0) |-> rd_addr == last_addr + AW'(4));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_status & $past(irq_status) & ~$past(irq_clr)) == '0));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assert_act_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_end[g] && !$past(ld_en && ld_ch == CHW'(g))) |->
        (!ctrl_q[g*CW + ACT_LO] && !ctrl_q[g*CW + ACT_HI]));
      assert_cmp_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_end[g] && $past(ctrl_q[g*CW + IRQEN_BIT])) |-> irq_status[CMP_SHIFT + g]);
      assert_result_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_end[g] && xfer_start[g]));
    end
  endgenerate

endmodule

bind dma_desc_fetch dma_desc_fetch_chk #(
  .NCH(NCH), .AW(AW), .CW(CW), .SW(SW), .CMP_SHIFT(CMP_SHIFT),
  .IRQEN_BIT(IRQEN_BIT), .ACT_LO(ACT_LO), .ACT_HI(ACT_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ch(ld_ch),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .xfer_start(xfer_start), .chain_end(chain_end), .ctrl_q(ctrl_q),
  .irq_status(irq_status), .irq_clr(irq_clr)
);

// File: tb/dma_desc_fetch_tb.sv
`timescale 1ns/1ps
module dma_desc_fetch_tb;
  localparam int NCH = 2;
  localparam logic [15:0] UNCH = 16'h0200, IEN = 16'h0400, ACT = 16'h5000;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0;
  logic [0:0] ld_ch = 0;
  logic [15:0] ld_ctrl = 0;
  logic [31:0] ld_next = 0;
  logic [NCH-1:0] xfer_done = 0, xfer_start, chain_end;
  logic rd_req, rd_valid = 0, irq;
  logic [31:0] rd_addr, rd_data = 0;
  logic [NCH*16-1:0] ctrl_q;
  logic [NCH*32-1:0] count_q, src_q, dst_q, next_q;
  logic [7:0] irq_status, irq_clr = 0, irq_mask = 0;

  int checks = 0, fails = 0;
  logic [31:0] mem [0:63];
  logic [31:0] alog [0:31];
  int n_rd = 0, lat = 0, wait_c = 0;
  logic pend_rd = 0;
  logic [31:0] pend_a = 0;

  always #4 clk = ~clk;

  dma_desc_fetch u_dut (.*);

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (pend_rd) begin
      if (wait_c == 0) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[pend_a[7:2]];
        pend_rd  <= 1'b0;
      end else wait_c <= wait_c - 1;
    end
    if (rd_req) begin
      pend_rd <= 1'b1;
      pend_a  <= rd_addr;
      wait_c  <= lat;
      if (n_rd < 32) alog[n_rd] <= rd_addr;
      n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int ch, input logic [15:0] c, input logic [31:0] n);
    @(negedge clk); ld_en = 1; ld_ch = ch[0:0]; ld_ctrl = c; ld_next = n;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic pulse_done(input logic [NCH-1:0] m);
    @(negedge clk); xfer_done = m;
    @(negedge clk); xfer_done = '0;
  endtask

  task automatic wait_start(input int ch, input string req);
    bit seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      if (xfer_start[ch]) seen = 1; else @(negedge clk);
    end
    chk(seen, req, 32'(seen), 1);
    @(negedge clk);
  endtask

  task automatic clear_status;
    @(negedge clk); irq_clr = 8'hFF;
    @(negedge clk); irq_clr = 8'h00;
  endtask

  function automatic logic [31:0] fld(input logic [NCH*32-1:0] v, input int ch);
    return v[ch*32 +: 32];
  endfunction

  task automatic t_reset;
    chk(ctrl_q == '0 && count_q == '0 && src_q == '0 && dst_q == '0 && next_q == '0,
        "R12 regs", count_q[31:0], 0);
    chk(irq_status == 0 && !irq && !rd_req && xfer_start == 0 && chain_end == 0,
        "R12 outputs", {irq_status, 7'b0, irq, 7'b0, rd_req}, 0);
  endtask

  task automatic t_chain;
    int base_rd;
    lat = 2;
    mem[16] = 32'h0000_0040; mem[17] = 32'h1000_1000; mem[18] = 32'h2000_2000; mem[19] = 32'h0000_0050;
    mem[20] = 32'h0000_0080; mem[21] = 32'h3000_3000; mem[22] = 32'h4000_4000; mem[23] = 32'h0000_0000;
    load(0, IEN | ACT | 16'h0003, 32'h40);
    base_rd = n_rd;
    pulse_done(2'b01);
    chk(chain_end == 0, "R8 no end on fetch", 32'(chain_end), 0);
    wait_start(0, "R8 start after first descriptor");
    chk(n_rd - base_rd == 4, "R1 four reads", n_rd - base_rd, 4);
    for (int k = 0; k < 4; k++)
      chk(alog[base_rd + k] == 32'h40 + 4*k, "R1 address order", alog[base_rd + k], 32'h40 + 4*k);
    chk(fld(count_q, 0) == 32'h40, "R2 count", fld(count_q, 0), 32'h40);
    chk(fld(src_q, 0) == 32'h1000_1000, "R2 source", fld(src_q, 0), 32'h1000_1000);
    chk(fld(dst_q, 0) == 32'h2000_2000, "R2 dest", fld(dst_q, 0), 32'h2000_2000);
    chk(fld(next_q, 0) == 32'h50, "R2 next", fld(next_q, 0), 32'h50);
    lat = 0;
    base_rd = n_rd;
    pulse_done(2'b01);
    wait_start(0, "R8 start after second descriptor");
    chk(alog[base_rd] == 32'h50 && alog[base_rd + 3] == 32'h5C, "R1 second link", alog[base_rd], 32'h50);
    chk(fld(count_q, 0) == 32'h80 && fld(next_q, 0) == 0, "R2 second link", fld(count_q, 0), 32'h80);
    base_rd = n_rd;
    irq_mask = 8'h10;
    pulse_done(2'b01);
    chk(chain_end == 2'b01, "R5 end on zero pointer", 32'(chain_end), 1);
    chk(irq_status == 8'h10, "R6 completion bit", irq_status, 8'h10);
    chk(irq, "R9 irq follows masked status", 32'(irq), 1);
    chk(ctrl_q[15:0] == (IEN | 16'h0003), "R7 active bits cleared", ctrl_q[15:0], IEN | 16'h0003);
    @(negedge clk);
    chk(chain_end == 0, "R8 end is a pulse", 32'(chain_end), 0);
    repeat (4) @(negedge clk);
    chk(n_rd == base_rd, "R5 no read on end", n_rd - base_rd, 0);
  endtask

  task automatic t_unchained;
    int base_rd;
    clear_status;
    irq_mask = 8'h00;
    load(1, UNCH | IEN | 16'h1000, 32'h40);
    base_rd = n_rd;
    pulse_done(2'b10);
    chk(chain_end == 2'b10, "R4 unchained ends", 32'(chain_end), 2);
    chk(irq_status == 8'h20, "R6 channel 1 bit", irq_status, 8'h20);
    chk(!irq, "R9 masked status gives no irq", 32'(irq), 0);
    irq_mask = 8'h20;
    #1;
    chk(irq, "R9 unmasked", 32'(irq), 1);
    chk(ctrl_q[31:16] == (UNCH | IEN), "R7 unchained clear", ctrl_q[31:16], UNCH | IEN);
    repeat (4) @(negedge clk);
    chk(n_rd == base_rd, "R4 no read", n_rd - base_rd, 0);
    chk(fld(count_q, 1) == 0 && fld(src_q, 1) == 0 && fld(dst_q, 1) == 0 && fld(next_q, 1) == 32'h40,
        "R4 registers kept", fld(next_q, 1), 32'h40);
    chk(irq_status == 8'h20, "R9 status held", irq_status, 8'h20);
    clear_status;
    chk(irq_status == 0 && !irq, "R9 clear", irq_status, 0);
  endtask

  task automatic t_no_irq;
    load(1, ACT | 16'h0100, 32'h0);
    pulse_done(2'b10);
    chk(chain_end == 2'b10, "R5 end without irq", 32'(chain_end), 2);
    chk(irq_status == 0, "R6 no bit when disabled", irq_status, 0);
    chk(ctrl_q[31:16] == 16'h0100, "R7 cleared without irq", ctrl_q[31:16], 16'h0100);
  endtask

  task automatic t_simul_end;
    load(0, IEN | ACT, 32'h0);
    load(1, IEN | UNCH | ACT, 32'h0);
    @(negedge clk); xfer_done = 2'b11; irq_clr = 8'h30;
    @(negedge clk); xfer_done = 2'b00; irq_clr = 8'h00;
    chk(chain_end == 2'b11, "R10 both end", 32'(chain_end), 3);
    chk(irq_status == 8'h30, "R10 both bits set, set beats clear", irq_status, 8'h30);
    clear_status;
  endtask

  task automatic t_simul_fetch;
    int base_rd;
    lat = 3;
    load(0, ACT, 32'h40);
    load(1, ACT, 32'h50);
    base_rd = n_rd;
    pulse_done(2'b11);
    wait_start(1, "R11 second channel loaded");
    chk(n_rd - base_rd == 8, "R11 eight reads", n_rd - base_rd, 8);
    for (int k = 0; k < 8; k++)
      chk(alog[base_rd + k] == 32'h40 + 4*k, "R11 lowest channel first, no interleave",
          alog[base_rd + k], 32'h40 + 4*k);
    chk(fld(next_q, 0) == 32'h50 && fld(src_q, 0) == 32'h1000_1000, "R11 channel 0 loaded",
        fld(src_q, 0), 32'h1000_1000);
    chk(fld(count_q, 1) == 32'h80 && fld(dst_q, 1) == 32'h4000_4000, "R11 channel 1 loaded",
        fld(dst_q, 1), 32'h4000_4000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_chain;
    t_unchained;
    t_no_irq;
    t_simul_end;
    t_simul_fetch;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule